// File: doc/BRIEF.md
# Coherent 16-bit Read Latch

This block sits between a bank of 16-bit status values that update on their own and a byte-wide read port. Software-visible registers are wider than the port, so each value is read as two bytes. When the live value moves between those two reads, a naive read could pair a low byte from one sample with a high byte from another. This block prevents that pairing.

One shadow slot is shared by every 16-bit register. Reading a low byte captures the high byte of that register in the same cycle. A later read of that register's high byte returns the captured copy and then empties the slot. A low-byte read of some other register takes the slot over. A high-byte read that does not match the slot returns the live byte. Reads answer one cycle after the strobe, so a low-then-high burst in back-to-back cycles behaves the same as two separate byte reads.

Top module: `coh_read_latch`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are zero and the slot is empty, so a high-byte read returns the live high byte.
- R2: `rd_valid` is high in the cycle after each cycle in which `rd_en` is high, and low in every other cycle. `rd_data` carries the answer in that same cycle.
- R3: Register k has its low byte at byte address 2k (address bit 0 clear) and its high byte at byte address 2k+1 (address bit 0 set).
- R4: A low-byte read returns bits 7:0 of the live value. In the same cycle it stores bits 15:8 of that value into the slot.
- R5: A high-byte read of the register held in the slot returns the stored byte, even when the live value has changed since, and then empties the slot.
- R6: After the slot has been emptied, a further high-byte read of the same register returns the live high byte.
- R7: A low-byte read of a different register replaces the slot contents. The previously held register then reads its live high byte.
- R8: A high-byte read of a register not in the slot returns the live high byte and leaves the slot unchanged.
- R9: A read at a byte address at or beyond 2*NUM_REGS returns 0x00 and leaves the slot unchanged.
- R10: A low read and a high read of the same register in consecutive cycles return the same bytes as separated reads, even when the live value changes between them.
- R11: A second low-byte read of the register already in the slot captures the current high byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_flat | input | NUM_REGS*16 | Live values; register k occupies bits 16k+15:16k |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | 8 | Byte read data |

## Verification
The hard case to reach from the ports is a high byte that differs between the live value and the slot, read at exactly the moment the slot matters. The bench changes the live value after the low read has been captured and before the high read. It also does this between the two halves of a back-to-back word read. Because the live and stored bytes differ, every expected value separates a correct stored reply from a live one. Further sequences place an unrelated high read, or an out-of-range read, between the low and high halves, to show that the slot survives them.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef logic [7:0] byte_t;

  // Classification of one read strobe
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LOW  = 2'd1,
    ACC_HIGH = 2'd2,
    ACC_VOID = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/coh_addr_decode.sv
module coh_addr_decode
  import coh_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 4,
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  logic in_range;

  assign idx      = rd_addr[ADDR_W-1:1];
  assign in_range = (int'(idx) < NUM_REGS);

  always_comb begin
    if (!rd_en)          kind = ACC_NONE;
    else if (!in_range)  kind = ACC_VOID;
    else if (rd_addr[0]) kind = ACC_HIGH;
    else                 kind = ACC_LOW;
  end

endmodule

// File: rtl/coh_live_mux.sv
module coh_live_mux
  import coh_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3,
  localparam int SLOTS   = 1 << IDX_W
) (
  input  logic [NUM_REGS*16-1:0] live_flat,
  input  logic [IDX_W-1:0]       idx,
  output byte_t                  live_lo,
  output byte_t                  live_hi
);

  logic [15:0] padded [SLOTS];

  // Pad the table to the full index range so any index selects a defined word
  for (genvar g = 0; g < SLOTS; g++) begin : g_pad
    if (g < NUM_REGS) begin : g_real
      assign padded[g] = live_flat[g*16 +: 16];
    end else begin : g_zero
      assign padded[g] = 16'h0000;
    end
  end

  assign live_lo = padded[idx][7:0];
  assign live_hi = padded[idx][15:8];

endmodule

// File: rtl/coh_freeze_slot.sv
module coh_freeze_slot
  import coh_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_kind_e        kind,
  input  logic [IDX_W-1:0] idx,
  input  byte_t            live_hi,
  input  logic             hit,
  output logic             slot_valid,
  output logic [IDX_W-1:0] slot_idx,
  output byte_t            slot_byte
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_idx   <= '0;
      slot_byte  <= '0;
    end else begin
      unique case (kind)
        ACC_LOW: begin
          // arm or move the slot onto this register
          slot_valid <= 1'b1;
          slot_idx   <= idx;
          slot_byte  <= live_hi;
        end
        ACC_HIGH: begin
          if (hit) slot_valid <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_read_latch.sv
module coh_read_latch
  import coh_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_REGS*16-1:0] live_flat,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   rd_valid,
  output logic [7:0]             rd_data
);

  localparam int IDX_W = ADDR_W - 1;

  acc_kind_e        kind;
  logic [IDX_W-1:0] idx;
  byte_t            live_lo;
  byte_t            live_hi;
  logic             slot_valid;
  logic [IDX_W-1:0] slot_idx;
  byte_t            slot_byte;
  logic             hit;

  coh_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) dec_i (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .kind    (kind),
    .idx     (idx)
  );

  coh_live_mux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) mux_i (
    .live_flat (live_flat),
    .idx       (idx),
    .live_lo   (live_lo),
    .live_hi   (live_hi)
  );

  assign hit = slot_valid && (slot_idx == idx);

  coh_freeze_slot #(.IDX_W(IDX_W)) slot_i (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .idx        (idx),
    .live_hi    (live_hi),
    .hit        (hit),
    .slot_valid (slot_valid),
    .slot_idx   (slot_idx),
    .slot_byte  (slot_byte)
  );

  // Registered read response
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      unique case (kind)
        ACC_LOW:  rd_data <= live_lo;
        ACC_HIGH: rd_data <= hit ? slot_byte : live_hi;
        ACC_VOID: rd_data <= 8'h00;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/coh_read_latch_chk.sv
module coh_read_latch_chk #(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 4,
  localparam int IDX_W   = ADDR_W - 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_REGS*16-1:0] live_flat,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic                   rd_valid,
  input logic [7:0]             rd_data,
  input logic                   slot_valid,
  input logic [IDX_W-1:0]       slot_idx,
  input logic [7:0]             slot_byte
);

  logic [IDX_W-1:0] c_idx;
  logic             c_in;
  logic             c_hi_sel;
  logic [7:0]       c_live_hi;
  logic [7:0]       c_live_lo;
  logic             c_match;
  logic             rst_q;

  assign c_idx     = rd_addr[ADDR_W-1:1];
  assign c_hi_sel  = rd_addr[0];
  assign c_in      = (int'(c_idx) < NUM_REGS);
  assign c_live_lo = 8'(live_flat >> (16 * int'(c_idx)));
  assign c_live_hi = 8'(live_flat >> (16 * int'(c_idx) + 8));
  assign c_match   = slot_valid && (slot_idx == c_idx);

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q && !rst) begin
      reset_state_chk: assert (!rd_valid && !slot_valid && rd_data == 8'h00);
    end
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R4
  low_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && c_in && !c_hi_sel) |=>
      (slot_valid && slot_idx == $past(c_idx) && slot_byte == $past(c_live_hi)
       && rd_data == $past(c_live_lo)));

  // R5
  frozen_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && c_in && c_hi_sel && c_match) |=>
      (!slot_valid && rd_data == $past(slot_byte)));

  // R8
  live_high_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && c_in && c_hi_sel && !c_match) |=>
      (rd_data == $past(c_live_hi) && $stable(slot_valid) && $stable(slot_byte)));

  // R9
  void_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !c_in) |=>
      (rd_data == 8'h00 && $stable(slot_valid) && $stable(slot_idx)));

endmodule

bind coh_read_latch coh_read_latch_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .live_flat  (live_flat),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .slot_valid (slot_valid),
  .slot_idx   (slot_idx),
  .slot_byte  (slot_byte)
);

// File: tb/coh_read_latch_tb.sv
module coh_read_latch_tb_top;

  localparam int NUM_REGS = 6;
  localparam int ADDR_W   = 4;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [15:0]            live [NUM_REGS];
  logic [NUM_REGS*16-1:0] live_flat;
  logic                   rd_en = 1'b0;
  logic [ADDR_W-1:0]      rd_addr = '0;
  logic                   rd_valid;
  logic [7:0]             rd_data;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;  // 200 MHz

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pack
    assign live_flat[g*16 +: 16] = live[g];
  end

  coh_read_latch #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .live_flat (live_flat),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // Driver: issue one read, push its expected byte; live changes after return
  // land after the capturing edge.
  task automatic rd(input int addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = ADDR_W'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_live(input int i, input logic [15:0] v);
    live[i] = v;
  endtask

  task automatic check_quiet(input string tag);
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s: rd_valid actual=%b expected=0", tag, rd_valid);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2: unexpected rd_valid, data actual=%h expected=none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s: rd_data actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_REGS; i++) live[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
      failures++;
      $display("FAIL R1: valid/data actual=%b/%h expected=0/00", rd_valid, rd_data);
    end

    // R1: empty slot after reset, high read gives live byte
    set_live(2, 16'hABCD);
    rd(5, 8'hAB, "R1");
    idle();
    check_quiet("R2");

    // R3 R4 R5 R6: capture, change, frozen return, then live
    set_live(1, 16'h1234);
    rd(2, 8'h34, "R3_R4");
    set_live(1, 16'h5678);
    idle();
    rd(3, 8'h12, "R5");
    rd(3, 8'h56, "R6");
    idle();

    // R7: slot moves to another register
    set_live(0, 16'h1111);
    rd(0, 8'h11, "R7");
    set_live(0, 16'h2222);
    set_live(3, 16'h3344);
    rd(6, 8'h44, "R7");
    set_live(3, 16'h5566);
    rd(1, 8'h22, "R7_prev_live");
    rd(7, 8'h33, "R7_new_frozen");
    idle();

    // R8: unrelated high read leaves slot alone
    set_live(4, 16'hA1B2);
    set_live(5, 16'h7788);
    rd(8, 8'hB2, "R8");
    set_live(4, 16'hC3D4);
    rd(11, 8'h77, "R8");
    rd(9, 8'hA1, "R8_slot_kept");
    idle();

    // R9: out-of-range reads
    set_live(2, 16'h9A0B);
    rd(4, 8'h0B, "R9");
    set_live(2, 16'h1C2D);
    rd(12, 8'h00, "R9");
    rd(15, 8'h00, "R9");
    rd(5, 8'h9A, "R9_slot_kept");
    idle();

    // R10: back-to-back word read with live change between halves
    set_live(5, 16'hFEDC);
    rd(10, 8'hDC, "R10");
    set_live(5, 16'h0102);
    rd(11, 8'hFE, "R10");
    idle();
    check_quiet("R2");

    // R11: repeated low read re-captures
    set_live(0, 16'h4455);
    rd(0, 8'h55, "R11");
    set_live(0, 16'h6677);
    rd(0, 8'h77, "R11");
    set_live(0, 16'h8899);
    rd(1, 8'h66, "R11");
    idle();
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2: pending replies actual=%0d expected=0", exp_q.size());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule